// File: doc/BRIEF.md
# Serial Configuration Stream Header Parser

This block watches a bit-serial configuration stream that arrives one bit per clock whenever a qualifying strobe is high. It finds the header, then checks the header fields. The header is a run of leading ones, a 4-bit sync pattern `0010`, a 24-bit stream length and four pad ones. The block keeps the stream length for downstream logic and then follows the data frames one by one. Every frame opens with a single start bit, which must be 0, and is followed by a fixed number of payload bits.

From the first bit of the stream, the parser counts every bit it accepts. This count includes any extra ones before the sync pattern. When the count reaches the captured stream length, the parser raises a completion flag and keeps it high. After that it takes no further input until a synchronous reset. Problems in the header pad and bad frame start bits raise sticky error flags. The parser does not check the payload and does not store it.

Top module: `cfgstream_hdr_parser`

## Requirements
- R1: After reset, every output is 0: the captured length, the length-valid flag, both pulses, the completion flag and both error flags.
- R2: The sync pattern `0010` is recognised only when the bit just before it is a 1. A `0010` with no 1 in front of it, such as at the very start of the stream, is not taken as the sync pattern.
- R3: The 24 bits after the sync pattern are the stream length, most significant bit first. One cycle after the 24th of these bits, `length_count` shows the value and `length_valid` is 1.
- R4: The four bits after the length must all be 1. If any of them is 0, then one cycle later `hdr_err` is set and stays set, `length_valid` drops to 0, and the parser hunts for a new sync pattern.
- R5: After a good pad, each frame starts with one start bit followed by FRAME_BITS payload bits (8 by default). A start bit of 0 gives a one-cycle `frame_start` pulse in the next cycle.
- R6: A start bit of 1 sets the sticky flag `frm_err` one cycle later. It gives no `frame_start` pulse, and that frame gives no `frame_valid` pulse.
- R7: One cycle after the last payload bit of a frame whose start bit was 0, `frame_valid` pulses for one cycle.
- R8: The bit count starts at the first accepted stream bit and includes all leading ones. `done` rises one cycle after the bit that brings the count to the captured length, and only if the length is valid at that bit.
- R9: Once `done` is high it stays high. After that, input bits change no output and give no pulses.
- R10: A cycle with `bit_valid` low consumes no bit: no pulse appears and no flag changes.
- R11: Holding `rst_n` low at a clock edge clears all state, including the bit count, the error flags and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial stream bit |
| length_count | output | LEN_W (24) | Captured stream length |
| length_valid | output | 1 | Length captured and pad not yet rejected |
| frame_start | output | 1 | Pulse: a good start bit was accepted |
| frame_valid | output | 1 | Pulse: a well-formed frame completed |
| done | output | 1 | Bit count reached the stream length (held) |
| hdr_err | output | 1 | Sticky: a pad bit was 0 |
| frm_err | output | 1 | Sticky: a frame start bit was 1 |

## Verification
Completion and frame tracking can land on the same bit. This happens when the stream length ends exactly on the last payload bit of a frame, and then `done` and `frame_valid` must both rise in the same cycle. One stream is built with its length chosen this way. A second stream ends its length partway through a payload, so `done` rises with no frame pulse, and the frame's later bits must produce nothing. A scoreboard predicts, bit by bit, both pulses and all the flags for each of these cycles and compares them with the outputs after the clock edge.

// File: rtl/cfgstream_pkg.sv
// Shared parser types and the fixed header encodings.
// Assumes: header layout is lead ones, sync pattern, length, pad ones.
package cfgstream_pkg;
    localparam int          SYNC_W   = 4;
    localparam logic [3:0]  SYNC_PAT = 4'b0010;
    localparam int          PAD_W    = 4;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_PAD,
        ST_FSTART,
        ST_FDATA,
        ST_DONE
    } parse_st_t;
endpackage

// File: rtl/cfg_sync_det.sv
// Sync pattern detector: a shift window that flags PATTERN when the bit
// just ahead of it was a 1. Assumes the window is cleared whenever the
// caller restarts hunting, so stale bits cannot form a match.
module cfg_sync_det #(
    parameter int         PAT_W   = 4,
    parameter logic [3:0] PATTERN = 4'b0010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic clear,
    input  logic bit_in,
    output logic hit
);
    logic [PAT_W-1:0] win;

    // Shift accepted bits into the window; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) win <= '0;
        else if (shift_en)   win <= {win[PAT_W-2:0], bit_in};
    end

    // Match = a 1 followed by the pattern, completed by the current bit.
    always_comb hit = shift_en && ({win, bit_in} == {1'b1, PATTERN});
endmodule

// File: rtl/cfg_bit_tally.sv
// Running count of accepted stream bits, compared with a target length.
// Assumes the count starts at zero from reset and that step is held
// low once the caller has finished.
module cfg_bit_tally #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         arm,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] total;
    logic [W-1:0] nxt;

    // Count one per accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    total <= '0;
        else if (step) total <= nxt;
    end

    // The current bit completes the stream when the new total matches.
    always_comb begin
        nxt = total + {{(W-1){1'b0}}, 1'b1};
        hit = arm && step && (nxt == target);
    end
endmodule

// File: rtl/cfgstream_hdr_parser.sv
// Configuration stream header parser. It hunts for the sync pattern,
// captures the stream length MSB first, checks the pad ones, then walks
// the data frames checking each start bit. It stops when the bit count
// reaches the length. Assumes one bit per cycle when bit_valid is high.
module cfgstream_hdr_parser
    import cfgstream_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FRAME_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [LEN_W-1:0] length_count,
    output logic             length_valid,
    output logic             frame_start,
    output logic             frame_valid,
    output logic             done,
    output logic             hdr_err,
    output logic             frm_err
);
    localparam int MAX_FLD = (LEN_W > FRAME_BITS) ?
                             ((LEN_W > PAD_W) ? LEN_W : PAD_W) :
                             ((FRAME_BITS > PAD_W) ? FRAME_BITS : PAD_W);
    localparam int CNT_W = $clog2(MAX_FLD + 1);
    localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN_W - 1);
    localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(PAD_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    parse_st_t        st;
    logic [CNT_W-1:0] fld_cnt;
    logic [LEN_W-2:0] len_sh;
    logic             frm_bad;
    logic             acc;
    logic             sync_hit;
    logic             pad_fail;
    logic             tally_hit;

    // A bit is consumed only while strobed and not yet complete.
    always_comb begin
        acc      = bit_valid && (st != ST_DONE);
        pad_fail = acc && (st == ST_PAD) && !bit_in;
    end

    cfg_sync_det #(
        .PAT_W  (SYNC_W),
        .PATTERN(SYNC_PAT)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(acc && (st == ST_HUNT)),
        .clear   (pad_fail),
        .bit_in  (bit_in),
        .hit     (sync_hit)
    );

    cfg_bit_tally #(
        .W(LEN_W)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (acc),
        .arm   (length_valid),
        .target(length_count),
        .hit   (tally_hit)
    );

    // Header and frame state machine with registered pulses and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_HUNT;
            fld_cnt      <= '0;
            len_sh       <= '0;
            length_count <= '0;
            length_valid <= 1'b0;
            frame_start  <= 1'b0;
            frame_valid  <= 1'b0;
            frm_bad      <= 1'b0;
            done         <= 1'b0;
            hdr_err      <= 1'b0;
            frm_err      <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            frame_valid <= 1'b0;
            if (acc) begin
                case (st)
                    ST_HUNT: begin
                        if (sync_hit) begin
                            st      <= ST_LEN;
                            fld_cnt <= '0;
                        end
                    end
                    ST_LEN: begin
                        len_sh <= {len_sh[LEN_W-3:0], bit_in};
                        if (fld_cnt == LEN_LAST) begin
                            length_count <= {len_sh, bit_in};
                            length_valid <= 1'b1;
                            st           <= ST_PAD;
                            fld_cnt      <= '0;
                        end else begin
                            fld_cnt <= fld_cnt + CNT_ONE;
                        end
                    end
                    ST_PAD: begin
                        if (!bit_in) begin
                            hdr_err      <= 1'b1;
                            length_valid <= 1'b0;
                            st           <= ST_HUNT;
                        end else if (fld_cnt == PAD_LAST) begin
                            st <= ST_FSTART;
                        end else begin
                            fld_cnt <= fld_cnt + CNT_ONE;
                        end
                    end
                    ST_FSTART: begin
                        frm_bad     <= bit_in;
                        frame_start <= !bit_in;
                        if (bit_in) frm_err <= 1'b1;
                        st      <= ST_FDATA;
                        fld_cnt <= '0;
                    end
                    ST_FDATA: begin
                        if (fld_cnt == DAT_LAST) begin
                            frame_valid <= !frm_bad;
                            st          <= ST_FSTART;
                        end else begin
                            fld_cnt <= fld_cnt + CNT_ONE;
                        end
                    end
                    default: st <= ST_DONE;
                endcase
                if (tally_hit) begin
                    st   <= ST_DONE;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgstream_hdr_parser_chk.sv
// Property checker for the stream parser, bound to the top module.
// Assumes the synchronous active-low reset of the parser.
module cfgstream_hdr_parser_chk #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic [LEN_W-1:0] length_count,
    input logic             length_valid,
    input logic             frame_start,
    input logic             frame_valid,
    input logic             done,
    input logic             hdr_err,
    input logic             frm_err
);
    a_r9_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    a_r9_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(length_count) && $stable(hdr_err) && $stable(frm_err)
                  && !frame_start && !frame_valid));
    a_r4_hdr_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> hdr_err);
    a_r6_frm_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |=> frm_err);
    a_r10_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> (!frame_start && !frame_valid && $stable(done)));
    a_r7_frame_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> length_valid);
    a_r5_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && frame_valid));
    a_r8_done_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(length_valid));
endmodule

bind cfgstream_hdr_parser cfgstream_hdr_parser_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .length_count(length_count),
    .length_valid(length_valid),
    .frame_start (frame_start),
    .frame_valid (frame_valid),
    .done        (done),
    .hdr_err     (hdr_err),
    .frm_err     (frm_err)
);

// File: tb/tb_cfgstream_hdr_parser.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push the predicted outputs for each
// cycle, and a monitor compares them shortly after the clock edge.
module tb_cfgstream_hdr_parser;
    localparam int LW = 24;
    localparam int FB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic [LW-1:0] length_count;
    logic          length_valid, frame_start, frame_valid, done, hdr_err, frm_err;

    cfgstream_hdr_parser #(.LEN_W(LW), .FRAME_BITS(FB)) dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .length_count(length_count), .length_valid(length_valid),
        .frame_start(frame_start), .frame_valid(frame_valid), .done(done),
        .hdr_err(hdr_err), .frm_err(frm_err)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic          fs, fv, dn, he, fe, lv;
        logic [LW-1:0] len;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // Bench model state, updated from the requirements only.
    int            tot;
    logic          e_done, e_he, e_fe, e_lv;
    logic [LW-1:0] e_len;
    logic          p_set_lv, p_clr_lv, p_he, p_fe;
    logic [LW-1:0] p_len;
    logic          gap_mode;

    task automatic chk1(input string what, input logic [LW-1:0] act,
                        input logic [LW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", what, tag, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk1("R5 frame_start", LW'(frame_start), LW'(e.fs), e.tag);
        chk1("R7 frame_valid", LW'(frame_valid), LW'(e.fv), e.tag);
        chk1("R8/R9 done", LW'(done), LW'(e.dn), e.tag);
        chk1("R4 hdr_err", LW'(hdr_err), LW'(e.he), e.tag);
        chk1("R6 frm_err", LW'(frm_err), LW'(e.fe), e.tag);
        chk1("R3 length_valid", LW'(length_valid), LW'(e.lv), e.tag);
        chk1("R3 length_count", length_count, e.len, e.tag);
    endtask

    // Monitor: one predicted item per driven cycle.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) compare(q.pop_front());
    end

    task automatic model_clear();
        tot = 0; e_done = 0; e_he = 0; e_fe = 0; e_lv = 0; e_len = '0;
        p_set_lv = 0; p_clr_lv = 0; p_he = 0; p_fe = 0; p_len = '0;
    endtask

    task automatic push_state(input logic fs, input logic fv, input string tag);
        exp_t e;
        e.fs = fs; e.fv = fv; e.dn = e_done; e.he = e_he; e.fe = e_fe;
        e.lv = e_lv; e.len = e_len; e.tag = tag;
        q.push_back(e);
    endtask

    // R10: an idle cycle consumes nothing.
    task automatic idle(input string tag);
        @(negedge clk);
        bit_valid = 1'b0;
        bit_in = 1'b1;
        push_state(1'b0, 1'b0, tag);
    endtask

    task automatic put(input logic b, input logic fs, input logic fv, input string tag);
        logic xfs, xfv;
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
        if (!e_done) begin
            tot++;
            if (e_lv && (tot == int'(e_len))) e_done = 1'b1;
            if (p_set_lv) begin e_lv = 1'b1; e_len = p_len; end
            if (p_clr_lv) e_lv = 1'b0;
            if (p_he) e_he = 1'b1;
            if (p_fe) e_fe = 1'b1;
            xfs = fs; xfv = fv;
        end else begin
            xfs = 1'b0; xfv = 1'b0;
        end
        p_set_lv = 0; p_clr_lv = 0; p_he = 0; p_fe = 0;
        push_state(xfs, xfv, tag);
        if (gap_mode && (tot % 7 == 3)) idle("R10 gap");
    endtask

    task automatic send_header(input int lead, input logic [LW-1:0] len);
        for (int i = 0; i < lead; i++) put(1'b1, 1'b0, 1'b0, "R8 lead one");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        put(1'b1, 1'b0, 1'b0, "R2 sync");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        for (int i = LW - 1; i >= 0; i--) begin
            if (i == 0) begin p_set_lv = 1; p_len = len; end
            put(len[i], 1'b0, 1'b0, "R3 length bit");
        end
        for (int i = 0; i < 4; i++) put(1'b1, 1'b0, 1'b0, "R4 pad");
    endtask

    task automatic send_frame(input logic sb, input logic [FB-1:0] d);
        if (sb) p_fe = 1;
        put(sb, !sb, 1'b0, sb ? "R6 bad start" : "R5 start");
        for (int j = FB - 1; j >= 0; j--)
            put(d[j], 1'b0, (j == 0) && !sb, "R7 payload");
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk1("R1 length_count", length_count, '0, tag);
        chk1("R1 flags", LW'({length_valid, frame_start, frame_valid, done, hdr_err, frm_err}),
             '0, tag);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        gap_mode = 0;
        model_clear();
        do_reset("R1 reset");

        // Stream 1: eight lead ones, three frames; the length ends on the
        // last payload bit, so done and frame_valid rise together (R8, R7).
        send_header(8, LW'(8 + 32 + 3 * (FB + 1)));
        send_frame(1'b0, 8'hA5);
        send_frame(1'b0, 8'h00);
        send_frame(1'b0, 8'hFF);
        // R9: later bits, including a sync-like pattern, change nothing.
        put(1'b1, 1'b0, 1'b0, "R9 after done");
        put(1'b0, 1'b0, 1'b0, "R9 after done");
        put(1'b0, 1'b0, 1'b0, "R9 after done");
        put(1'b1, 1'b0, 1'b0, "R9 after done");
        put(1'b0, 1'b0, 1'b0, "R9 after done");
        drain();

        // R11: reset clears done; stream 2 uses strobe gaps (R10),
        // a bad start bit (R6) and ends mid-payload.
        do_reset("R11 reset clears");
        gap_mode = 1;
        send_header(13, LW'(13 + 32 + (FB + 1) + 4));
        send_frame(1'b1, 8'h3C);
        send_frame(1'b0, 8'h81);
        send_frame(1'b0, 8'h7E);
        gap_mode = 0;
        drain();

        // Stream 3: 0010 with no lead one (R2), then a pad error (R4),
        // then a fresh header whose length counts every bit so far (R8).
        do_reset("R11 reset again");
        put(1'b0, 1'b0, 1'b0, "R2 no lead");
        put(1'b0, 1'b0, 1'b0, "R2 no lead");
        put(1'b1, 1'b0, 1'b0, "R2 no lead");
        put(1'b0, 1'b0, 1'b0, "R2 no lead");
        put(1'b1, 1'b0, 1'b0, "R2 lead");
        put(1'b1, 1'b0, 1'b0, "R2 lead");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        put(1'b1, 1'b0, 1'b0, "R2 sync");
        put(1'b0, 1'b0, 1'b0, "R2 sync");
        for (int i = LW - 1; i >= 0; i--) begin
            if (i == 0) begin p_set_lv = 1; p_len = LW'(24'h00ABCD); end
            put(24'h00ABCD >> i, 1'b0, 1'b0, "R3 length bit");
        end
        put(1'b1, 1'b0, 1'b0, "R4 pad");
        put(1'b1, 1'b0, 1'b0, "R4 pad");
        p_he = 1; p_clr_lv = 1;
        put(1'b0, 1'b0, 1'b0, "R4 pad zero");
        send_header(1, LW'(tot + 1 + 32 + (FB + 1)));
        send_frame(1'b0, 8'h5A);
        put(1'b0, 1'b0, 1'b0, "R9 after done");
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule